// File: doc/BRIEF.md
# Banked Cartridge Memory Mapper

This block sits on the cartridge side of an 8-bit handheld console that has a 16-bit address bus. CPU writes into the lower 32 KiB are not treated as memory writes. They load control registers. Those registers set three windows: a fixed 16 KiB ROM window, a switchable 16 KiB ROM window and an 8 KiB external RAM window.

A single 2-bit register has two roles. In ROM-banking mode it supplies the top two bits of the 7-bit ROM bank. In RAM-banking mode it supplies the RAM bank number. A mode register chooses the role. The low five ROM bank bits can never read back as zero.

Each CPU access is registered once. One clock edge later the block presents a ROM or RAM address with its strobes. Read data returns on `cpu_rdata` in that same cycle, taken from whichever memory was selected, or 0xFF when no memory was selected. The ROM and RAM arrays live outside the block.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, the mode is ROM-banking, external RAM is disabled and neither `rom_rd` nor `ram_cs` is asserted.
- R2: A write to 0x0000–0x1FFF enables external RAM when data[3:0] equals 0xA. Any other value disables it.
- R3: A write to 0x2000–0x3FFF loads ROM bank bits 4:0 from data[4:0] and leaves bits 6:5 unchanged. A zero in bits 4:0 is stored as 1, so 0x00/0x20/0x40/0x60 select 0x01/0x21/0x41/0x61.
- R4: A write to 0x4000–0x5FFF loads data[1:0] into the shared 2-bit register. In ROM-banking mode this value is ROM bank bits 6:5. In RAM-banking mode it is the RAM bank.
- R5: A write to 0x6000–0x7FFF sets the mode from data[0], where 1 means RAM-banking. On entering RAM-banking mode, ROM bank bits 6:5 become the RAM bank and read as zero in the ROM bank. On leaving it, the RAM bank returns to ROM bank bits 6:5 and the RAM bank becomes 0. Writing the mode that is already set changes nothing.
- R6: A read at 0x0000–0x3FFF asserts `rom_rd` one cycle later, with `rom_addr` equal to addr[13:0] and all upper bits zero.
- R7: A read at 0x4000–0x7FFF asserts `rom_rd` one cycle later, with `rom_addr` = {ROM bank, addr[13:0]}.
- R8: An access at 0xA000–0xBFFF asserts `ram_cs` one cycle later, with `ram_addr` = {RAM bank, addr[12:0]}. For a write it also asserts `ram_we` and presents the data on `ram_wdata`.
- R9: A RAM access is dropped when RAM is disabled or when its offset is at or beyond `RAM_SIZE`. In that case `ram_cs` stays low and a dropped read returns 0xFF.
- R10: Read data appears on `cpu_rdata` in the cycle after the request. Reads at 0x8000–0x9FFF and 0xC000–0xFFFF return 0xFF and select no memory.
- R11: `rom_rd` and `ram_cs` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| rom_addr | output | ROM_AW | Registered ROM byte address |
| rom_rd | output | 1 | ROM read select |
| rom_rdata | input | 8 | ROM data for `rom_addr` |
| ram_addr | output | RAM_AW | Registered RAM byte address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM data for `ram_addr` |

## Verification
The bench first runs directed sequences. These separate the zero-forcing of the low bank bits from plain loads, show the shared register moving between its ROM and RAM roles in both directions, and confirm that repeating the current mode leaves everything alone. RAM enable is tried with values whose low nibble is and is not 0xA, with non-zero upper nibbles in both cases. RAM banks 2 and 3 drive offsets past `RAM_SIZE` to show that such accesses are dropped. A long random mix of control writes and reads in every region, checked against an independent model that moves bits explicitly on mode change, exposes any ordering fault between register updates and the translation of the next access.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  typedef enum logic [1:0] {
    RG_ROM_FIX = 2'd0,
    RG_ROM_SW  = 2'd1,
    RG_RAM     = 2'd2,
    RG_NONE    = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    CW_RAMEN  = 2'd0,
    CW_BANKLO = 2'd1,
    CW_SHARED = 2'd2,
    CW_MODE   = 2'd3
  } ctrl_e;

  typedef enum logic [1:0] {
    SRC_OPEN = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2
  } src_e;

  function automatic region_e region_of(input logic [15:0] a);
    if (!a[15])                 return a[14] ? RG_ROM_SW : RG_ROM_FIX;
    else if (a[15:13] == 3'b101) return RG_RAM;
    else                        return RG_NONE;
  endfunction

endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import cart_map_pkg::*;
#(
  parameter int LO_W = 5,
  parameter int HI_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  ctrl_e                sel,
  input  logic [7:0]           wdata,
  output logic                 ram_on,
  output logic                 ram_mode,
  output logic [LO_W+HI_W-1:0] rom_bank,
  output logic [HI_W-1:0]      ram_bank
);

  localparam int BANK_W = LO_W + HI_W;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_on   <= 1'b0;
      ram_mode <= 1'b0;
      lo_q     <= LO_W'(1);
      hi_q     <= '0;
    end else if (wr_en) begin
      unique case (sel)
        CW_RAMEN:  ram_on <= (wdata[3:0] == 4'hA);
        CW_BANKLO: lo_q   <= (wdata[LO_W-1:0] == '0) ? LO_W'(1) : wdata[LO_W-1:0];
        CW_SHARED: hi_q   <= wdata[HI_W-1:0];
        CW_MODE:   ram_mode <= wdata[0];
        default:   ;
      endcase
    end
  end

  // The shared register never moves: the mode only decides which output sees it.
  assign rom_bank = ram_mode ? {{HI_W{1'b0}}, lo_q} : {hi_q, lo_q};
  assign ram_bank = ram_mode ? hi_q : '0;

  // R3
  lo_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    rom_bank[LO_W-1:0] != '0);

  // R5
  mode_conserve_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == CW_MODE) |=>
      ((rom_bank[BANK_W-1:LO_W] | ram_bank) == $past(rom_bank[BANK_W-1:LO_W] | ram_bank)));

  // R5
  same_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == CW_MODE && wdata[0] == ram_mode) |=>
      ($stable(rom_bank) && $stable(ram_bank)));

endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import cart_map_pkg::*;
#(
  parameter int BANK_W   = 7,
  parameter int RBANK_W  = 2,
  parameter int ROM_WIN  = 14,
  parameter int RAM_WIN  = 13,
  parameter int RAM_SIZE = 16384,
  parameter int ROM_AW   = BANK_W + ROM_WIN,
  parameter int RAM_AW   = RBANK_W + RAM_WIN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic               cpu_wr,
  input  logic               cpu_rd,
  input  logic [BANK_W-1:0]  rom_bank,
  input  logic [RBANK_W-1:0] ram_bank,
  input  logic               ram_on,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic               rom_rd,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic               ram_cs,
  output logic               ram_we,
  output logic [7:0]         ram_wdata,
  output src_e               src
);

  region_e           region;
  logic              rd_only;
  logic              rom_hit;
  logic              ram_hit;
  logic              in_range;
  logic [RAM_AW-1:0] ram_off;

  always_comb begin
    region   = region_of(cpu_addr);
    rd_only  = cpu_rd && !cpu_wr;
    ram_off  = {ram_bank, cpu_addr[RAM_WIN-1:0]};
    in_range = (32'(ram_off) < 32'(RAM_SIZE));
    rom_hit  = rd_only && (region == RG_ROM_FIX || region == RG_ROM_SW);
    ram_hit  = (cpu_rd || cpu_wr) && (region == RG_RAM) && ram_on && in_range;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr  <= '0;
      rom_rd    <= 1'b0;
      ram_addr  <= '0;
      ram_cs    <= 1'b0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
      src       <= SRC_OPEN;
    end else begin
      rom_rd <= rom_hit;
      ram_cs <= ram_hit;
      ram_we <= ram_hit && cpu_wr;
      if (rom_hit)
        rom_addr <= (region == RG_ROM_FIX) ? {{BANK_W{1'b0}}, cpu_addr[ROM_WIN-1:0]}
                                           : {rom_bank, cpu_addr[ROM_WIN-1:0]};
      if (ram_hit)
        ram_addr <= ram_off;
      if (ram_hit && cpu_wr)
        ram_wdata <= cpu_wdata;
      if (rom_hit)                src <= SRC_ROM;
      else if (ram_hit && rd_only) src <= SRC_RAM;
      else                        src <= SRC_OPEN;
    end
  end

  // R11
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_rd, ram_cs}));

  // R9
  ram_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ram_cs |-> $past(ram_on));

  // R9
  ram_range_chk: assert property (@(posedge clk) disable iff (rst)
    ram_cs |-> (32'(ram_addr) < 32'(RAM_SIZE)));

  // R6
  fixed_win_chk: assert property (@(posedge clk) disable iff (rst)
    (rom_rd && $past(cpu_addr[15:14] == 2'b00)) |-> (rom_addr[ROM_AW-1:ROM_WIN] == '0));

  // R7
  sw_win_chk: assert property (@(posedge clk) disable iff (rst)
    (rom_rd && $past(cpu_addr[15:14] == 2'b01)) |-> (rom_addr[ROM_AW-1:ROM_WIN] == $past(rom_bank)));

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int ROM_LO_W = 5,
  parameter int SHARE_W  = 2,
  parameter int RAM_SIZE = 16384,
  parameter int ROM_AW   = ROM_LO_W + SHARE_W + 14,
  parameter int RAM_AW   = SHARE_W + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_rd,
  input  logic [7:0]        rom_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);

  localparam int BANK_W = ROM_LO_W + SHARE_W;

  logic               ctrl_wr;
  ctrl_e              ctrl_sel;
  logic               ram_on;
  logic               ram_mode;
  logic [BANK_W-1:0]  rom_bank;
  logic [SHARE_W-1:0] ram_bank;
  src_e               src;

  assign ctrl_wr  = cpu_wr && !cpu_addr[15];
  assign ctrl_sel = ctrl_e'(cpu_addr[14:13]);

  mapper_ctrl #(.LO_W(ROM_LO_W), .HI_W(SHARE_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ctrl_wr),
    .sel      (ctrl_sel),
    .wdata    (cpu_wdata),
    .ram_on   (ram_on),
    .ram_mode (ram_mode),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank)
  );

  mapper_xlate #(
    .BANK_W   (BANK_W),
    .RBANK_W  (SHARE_W),
    .ROM_WIN  (14),
    .RAM_WIN  (13),
    .RAM_SIZE (RAM_SIZE),
    .ROM_AW   (ROM_AW),
    .RAM_AW   (RAM_AW)
  ) u_xlate (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .ram_on    (ram_on),
    .rom_addr  (rom_addr),
    .rom_rd    (rom_rd),
    .ram_addr  (ram_addr),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .src       (src)
  );

  always_comb begin
    unique case (src)
      SRC_ROM: cpu_rdata = rom_rdata;
      SRC_RAM: cpu_rdata = ram_rdata;
      default: cpu_rdata = 8'hFF;
    endcase
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rom_rd && !ram_cs && !ram_we));

  // R10
  open_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (!rom_rd && !ram_cs) |-> (cpu_rdata == 8'hFF));

  // R5
  ram_mode_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_cs && !$past(ram_mode)) |-> (ram_addr[RAM_AW-1:13] == '0));

endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;

  localparam int RAM_SIZE = 16384;
  localparam int ROM_AW   = 21;
  localparam int RAM_AW   = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic              cpu_wr = 1'b0;
  logic              cpu_rd = 1'b0;
  logic [7:0]        cpu_rdata;
  logic [ROM_AW-1:0] rom_addr;
  logic              rom_rd;
  logic [7:0]        rom_rdata;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_cs;
  logic              ram_we;
  logic [7:0]        ram_wdata;
  logic [7:0]        ram_rdata = '0;

  always #4 clk = ~clk;

  cart_bank_mapper #(.RAM_SIZE(RAM_SIZE)) dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_rdata(rom_rdata),
    .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] a);
    return a[7:0] ^ {a[20:14], 1'b1};
  endfunction

  // external memories
  assign rom_rdata = rom_byte(rom_addr);
  logic [7:0] ram_mem [int];

  always @(posedge clk) begin
    if (ram_cs && ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
    #1;
    ram_rdata = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h00;
  end

  // scoreboard
  typedef struct {
    int                due;
    bit                rom_rd;
    logic [ROM_AW-1:0] rom_addr;
    bit                ram_cs;
    bit                ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [7:0]        wdata;
    bit                chk_rd;
    logic [7:0]        rdata;
    string             req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference model
  bit         m_en = 0;
  bit         m_mode = 0;
  logic [6:0] m_bank = 7'd1;
  logic [1:0] m_rbank = 2'd0;
  logic [7:0] ref_ram [int];

  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d, input string req);
    exp_t e;
    logic [RAM_AW-1:0] off;
    bit hit;
    @(negedge clk);
    e.due = cyc + 1; e.req = req;
    e.rom_rd = 0; e.rom_addr = '0; e.ram_cs = 0; e.ram_we = 0;
    e.ram_addr = '0; e.wdata = d; e.chk_rd = !wr; e.rdata = 8'hFF;
    if (a[15:13] == 3'b101) begin
      off = {m_rbank, a[12:0]};
      hit = m_en && (int'(off) < RAM_SIZE);
      e.ram_cs = hit; e.ram_we = hit && wr; e.ram_addr = off;
      if (hit && !wr) e.rdata = ref_ram.exists(int'(off)) ? ref_ram[int'(off)] : 8'h00;
      if (hit && wr) ref_ram[int'(off)] = d;
    end else if (!a[15] && !wr) begin
      e.rom_rd = 1;
      e.rom_addr = a[14] ? {m_bank, a[13:0]} : {7'd0, a[13:0]};
      e.rdata = rom_byte(e.rom_addr);
    end else if (!a[15] && wr) begin
      if (a < 16'h2000) m_en = (d[3:0] == 4'hA);
      else if (a < 16'h4000) begin
        m_bank[4:0] = d[4:0];
        if (m_bank[4:0] == 5'd0) m_bank[0] = 1'b1;
      end else if (a < 16'h6000) begin
        if (m_mode) m_rbank = d[1:0]; else m_bank[6:5] = d[1:0];
      end else if (d[0] != m_mode) begin
        m_mode = d[0];
        if (m_mode) begin m_rbank = m_bank[6:5]; m_bank[6:5] = 2'd0; end
        else begin m_bank[6:5] = m_rbank; m_rbank = 2'd0; end
      end
    end
    cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = !wr;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      bad = (rom_rd !== e.rom_rd) || (e.rom_rd && rom_addr !== e.rom_addr) ||
            (ram_cs !== e.ram_cs) || (ram_we !== e.ram_we) ||
            (e.ram_cs && ram_addr !== e.ram_addr) ||
            (e.ram_we && ram_wdata !== e.wdata) ||
            (e.chk_rd && cpu_rdata !== e.rdata);
      n_vec++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s: act rom_rd=%0b rom_addr=%h ram_cs=%0b ram_we=%0b ram_addr=%h wdata=%h rdata=%h | exp rom_rd=%0b rom_addr=%h ram_cs=%0b ram_we=%0b ram_addr=%h wdata=%h rdata=%h",
                 e.req, rom_rd, rom_addr, ram_cs, ram_we, ram_addr, ram_wdata, cpu_rdata,
                 e.rom_rd, e.rom_addr, e.ram_cs, e.ram_we, e.ram_addr, e.wdata, e.rdata);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: idle outputs after reset
    n_vec++;
    if (rom_rd !== 1'b0 || ram_cs !== 1'b0 || cpu_rdata !== 8'hFF) begin
      n_bad++;
      $display("FAIL R1: act rom_rd=%0b ram_cs=%0b rdata=%h exp 0 0 ff", rom_rd, ram_cs, cpu_rdata);
    end
    access(0, 16'h4123, 8'h00, "R1_r7_reset_bank");
    access(0, 16'hA010, 8'h00, "R1_r9_ram_disabled");
    access(0, 16'h1234, 8'h00, "R6_fixed");
    access(0, 16'h3FFF, 8'h00, "R6_fixed_top");
    // R3 zero forcing
    access(1, 16'h2000, 8'h00, "R3_zero");
    access(0, 16'h4000, 8'h00, "R3_zero_read");
    access(1, 16'h3ABC, 8'hE5, "R3_load");
    access(0, 16'h7FFF, 8'h00, "R3_load_read");
    // R4 upper bits in ROM mode, then 0x20 -> 0x21
    access(1, 16'h4000, 8'hFD, "R4_upper");
    access(1, 16'h2000, 8'h20, "R3_hi_zero");
    access(0, 16'h4555, 8'h00, "R4_r3_bank21");
    // R2 enable variants
    access(1, 16'h0000, 8'h1A, "R2_enable_hi_nibble");
    access(1, 16'hA004, 8'h5C, "R8_write_bank0");
    access(0, 16'hA004, 8'h00, "R8_read_back");
    access(1, 16'h1FFF, 8'h0B, "R2_disable");
    access(0, 16'hA004, 8'h00, "R2_r9_blocked");
    access(1, 16'h0100, 8'h0A, "R2_enable");
    // R5 enter RAM mode: shared bits 01 move to RAM bank
    access(1, 16'h6000, 8'h01, "R5_enter");
    access(0, 16'h4001, 8'h00, "R5_rom_hi_cleared");
    access(1, 16'hBFFF, 8'h77, "R5_r8_ram_bank1");
    access(1, 16'h7000, 8'hFF, "R5_same_mode");
    access(0, 16'hBFFF, 8'h00, "R5_same_mode_read");
    access(1, 16'h5000, 8'h02, "R4_r9_bank2_oob");
    access(1, 16'hA100, 8'h33, "R9_oob_write");
    access(0, 16'hA100, 8'h00, "R9_oob_read");
    access(1, 16'h4000, 8'h01, "R4_bank1");
    // R5 leave: RAM bank 1 returns to ROM bits 6:5
    access(1, 16'h6000, 8'h00, "R5_leave");
    access(0, 16'h4002, 8'h00, "R5_rom_hi_back");
    access(0, 16'hA004, 8'h00, "R5_ram_bank0");
    access(0, 16'h8123, 8'h00, "R10_open_low");
    access(0, 16'hC000, 8'h00, "R10_open_high");
    access(1, 16'hE000, 8'h99, "R10_write_ignored");
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [15:0] a;
      logic [7:0] d;
      k = $urandom_range(0, 9);
      d = 8'($urandom);
      a = 16'($urandom);
      case (k)
        0: begin a = {3'b000, a[12:0]}; if (d[7]) d[3:0] = 4'hA; access(1, a, d, "R2_rand"); end
        1: access(1, {3'b001, a[12:0]}, d, "R3_rand");
        2: access(1, {3'b010, a[12:0]}, d, "R4_rand");
        3: access(1, {3'b011, a[12:0]}, d, "R5_rand");
        4: access(0, {2'b00, a[13:0]}, d, "R6_rand");
        5: access(0, {2'b01, a[13:0]}, d, "R7_rand");
        6, 7: access(k == 6, {3'b101, a[12:0]}, d, "R8_r9_rand");
        8: access(0, {3'b101, a[12:0]}, d, "R8_r11_rand");
        default: begin
          if (a[15:13] == 3'b101 || !a[15]) a[15:13] = 3'b110;
          access(a[0], a, d, "R10_rand");
        end
      endcase
      if (k == 9) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule